// File: doc/BRIEF.md
# Root Port Bridge Configuration Register File

This block holds the configuration registers of a PCI Express root port that has to present itself to host software as a PCI-to-PCI bridge. It stores a sixteen-dword Type 1 header and, when a parameter enables it, a fifteen-dword PCI Express capability structure placed directly after the header. Every bit of every dword carries exactly one access attribute: read-only, read-write, write-one-to-clear or reserved. The block applies these attributes on each access, so software always sees consistent values and can never change an identity field.

The host reaches the registers through a single request channel. Each request carries a byte address, a size of 1, 2 or 4 bytes and, for writes, data. The response comes back one cycle after the request is accepted. Sub-dword writes are merged into the stored dword through a byte-lane mask. Every write that changes state is reported on a notification port with the dword index, the value before and after the write, and the lane mask. Logic elsewhere can react to new settings there. A status-set port lets the surrounding hardware raise write-one-to-clear event bits, which software then acknowledges.

Top module: `rp_cfg_space`

## Requirements
- R1: Reset values. Dword 0 = ID_WORD. Dword 1 = 0x0010_0000 (capability-list flag). Dword 2 = 0x0604_00 followed by REV_ID in the low byte. Dword 3 = 0x0001_0010. Dword 13 = 0x40 with the capability enabled and 0 without it. Dword 16 = 0x0142_0010. All other dwords are 0.
- R2: A bit in a reserved mask always reads 0. The reserved masks are: d1 0x004F_FC00, d7 0x005F_0000, d13 0xFFFF_FF00, d14 0x0000_07FE, d15 0xF010_0000, d18 0xFFE0_0000, d19 0x0080_0000, d20 0x0000_F004, d22 0xFE00_F000, d23 0xFFFE_FFE0, d24 0xFFFC_0000.
- R3: A read of size 1 or 2 returns the dword shifted right by 8 times addr[1:0], then masked to 8 or 16 bits. A read of size 4 returns the whole dword.
- R4: A size code other than 1, 2 or 4 gives rsp_err = 1 and rsp_rdata = 0, and it changes no register.
- R5: A write shifts its data left by 8 times addr[1:0]. The lane mask is 0xFF or 0xFFFF shifted the same way, or all ones for size 4. Only read-write bits inside the lane mask take the shifted data; every other bit keeps its value.
- R6: A write-one-to-clear bit inside the lane mask is cleared when its shifted data bit is 1 and kept when it is 0. set_valid with set_bits sets the write-one-to-clear bits of dword set_idx, and a set beats a clear in the same cycle. The W1C masks are: d1 and d7 0xF900_0000, d15 0x0400_0000, d18 0x000F_0000, d20 0xC000_0000, d22 0x011F_0000, d24 0x0001_0000.
- R7: Bits outside the read-write and write-one-to-clear masks never change from their reset value.
- R8: The active window is dwords 0-15, plus dwords 16-30 (up to byte 0x7B) when HAS_PCIE = 1. Outside it, reads return 0 and writes change nothing and raise no notification.
- R9: Each in-window write of a legal size pulses ntf_valid one cycle after acceptance. The pulse carries the dword index, the old value with reserved bits cleared, the new value and the lane mask.
- R10: req_ready is high from the first clock after reset. rsp_valid pulses exactly one cycle after each accepted request, for reads and for writes, and at no other time. One request at most is accepted per cycle.
- R11: The header read-write masks are: d1 0x0000_0147, d6 0x00FF_FFFF, d7 0x0000_F0F0, d8 and d9 0xFFF0_FFF0, d10-d12 all ones, d14 0xFFFF_F801, d15 0x0B6F_00FF.
- R12: The capability read-write masks are: d18 0x0000_FFFF, d20 0x0000_0FFB, d22 0x0000_1FFF, d23 0x0000_001F. All other capability bits are read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-aligned |
| set_valid | input | 1 | Hardware status-set strobe |
| set_idx | input | ADDR_W-2 | Dword index for the status set |
| set_bits | input | 32 | Bits to raise (only W1C bits take effect) |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Illegal access size |
| rsp_rdata | output | 32 | Read data, right-aligned |
| ntf_valid | output | 1 | Write notification pulse |
| ntf_index | output | ADDR_W-2 | Dword index written |
| ntf_old | output | 32 | Dword value before the write |
| ntf_new | output | 32 | Dword value after the write |
| ntf_mask | output | 32 | Byte-lane mask of the write |

## Verification
A wrong attribute mask or a bad merge in one dword shows up at the ports on the next access to that dword. The notification pulse one cycle after the write exposes the bad new value, and the following full-dword read returns it. Identity fields altered by a write, or reserved bits that leak, show up on the next full read of that dword. The sweep writes and reads back every dword under every size and offset, so a fault appears within a few cycles of the first access that reaches it. An error in the window limit or the status-set path shows up on the very next out-of-window read or on the read-back after a set.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned HDR_DW = 16;
  localparam int unsigned CAP_DW = 15;

  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    word_t rw;
    word_t w1c;
    word_t rsvd;
  } bit_attr_t;

  // Per-dword access attributes; anything not listed is read-only.
  function automatic bit_attr_t dw_attr(input int unsigned idx);
    bit_attr_t a;
    a = '0;
    case (idx)
      1:          begin a.rw = 32'h0000_0147; a.w1c = 32'hF900_0000; a.rsvd = 32'h004F_FC00; end
      6:          a.rw = 32'h00FF_FFFF;
      7:          begin a.rw = 32'h0000_F0F0; a.w1c = 32'hF900_0000; a.rsvd = 32'h005F_0000; end
      8, 9:       a.rw = 32'hFFF0_FFF0;
      10, 11, 12: a.rw = 32'hFFFF_FFFF;
      13:         a.rsvd = 32'hFFFF_FF00;
      14:         begin a.rw = 32'hFFFF_F801; a.rsvd = 32'h0000_07FE; end
      15:         begin a.rw = 32'h0B6F_00FF; a.w1c = 32'h0400_0000; a.rsvd = 32'hF010_0000; end
      18:         begin a.rw = 32'h0000_FFFF; a.w1c = 32'h000F_0000; a.rsvd = 32'hFFE0_0000; end
      19:         a.rsvd = 32'h0080_0000;
      20:         begin a.rw = 32'h0000_0FFB; a.w1c = 32'hC000_0000; a.rsvd = 32'h0000_F004; end
      22:         begin a.rw = 32'h0000_1FFF; a.w1c = 32'h011F_0000; a.rsvd = 32'hFE00_F000; end
      23:         begin a.rw = 32'h0000_001F; a.rsvd = 32'hFFFE_FFE0; end
      24:         begin a.w1c = 32'h0001_0000; a.rsvd = 32'hFFFC_0000; end
      default:    a = '0;
    endcase
    return a;
  endfunction

  function automatic word_t dw_init(input int unsigned idx, input word_t id_word,
                                    input logic [7:0] rev, input bit pcie);
    word_t v;
    case (idx)
      0:       v = id_word;
      1:       v = 32'h0010_0000;
      2:       v = {24'h0604_00, rev};
      3:       v = 32'h0001_0010;
      13:      v = pcie ? 32'h0000_0040 : 32'h0;
      16:      v = 32'h0142_0010;
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/rpc_lane.sv
module rpc_lane
  import rpc_pkg::*;
(
  input  logic [1:0] ofs,
  input  logic [2:0] size,
  input  word_t      wdata,
  input  word_t      old,
  input  word_t      rw_m,
  input  word_t      w1c_m,
  output logic       size_ok,
  output word_t      lane_m,
  output word_t      merged,
  output word_t      rd_val
);
  logic [4:0] sh;
  word_t      wsh;

  always_comb begin
    sh  = {ofs, 3'b000};
    wsh = wdata << sh;
    case (size)
      3'd1: begin
        size_ok = 1'b1;
        lane_m  = 32'h0000_00FF << sh;
        rd_val  = (old >> sh) & 32'h0000_00FF;
      end
      3'd2: begin
        size_ok = 1'b1;
        lane_m  = 32'h0000_FFFF << sh;
        rd_val  = (old >> sh) & 32'h0000_FFFF;
      end
      3'd4: begin
        size_ok = 1'b1;
        lane_m  = '1;
        rd_val  = old;
      end
      default: begin
        size_ok = 1'b0;
        lane_m  = '0;
        rd_val  = '0;
      end
    endcase
    merged = (old & ~(rw_m & lane_m)) | (wsh & rw_m & lane_m);
    merged = merged & ~(wsh & w1c_m & lane_m);
  end
endmodule

// File: rtl/rpc_dword.sv
module rpc_dword
  import rpc_pkg::*;
#(
  parameter int unsigned IDX      = 0,
  parameter logic [31:0] ID_WORD  = 32'h0,
  parameter logic [7:0]  REV_ID   = 8'h0,
  parameter bit          HAS_PCIE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  word_t wr_val,
  input  logic  set_en,
  input  word_t set_bits,
  output word_t rd
);
  localparam bit_attr_t ATTR = dw_attr(IDX);
  localparam word_t     INIT = dw_init(IDX, ID_WORD, REV_ID, HAS_PCIE);
  localparam word_t     WR_M = ATTR.rw | ATTR.w1c;

  word_t q, d;
  logic  ld;

  always_comb begin
    ld = wr_en | set_en;
    d  = q;
    if (wr_en)  d = (q & ~WR_M) | (wr_val & WR_M);
    if (set_en) d = d | (set_bits & ATTR.w1c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= INIT;
    else if (ld) q <= d;
  end

  assign rd = q & ~ATTR.rsvd;

  // R6: a raised event bit is visible on the next cycle
  assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !wr_en) |=> ((rd & $past(set_bits) & ATTR.w1c) == ($past(set_bits) & ATTR.w1c)));
endmodule

// File: rtl/rp_cfg_space.sv
module rp_cfg_space
  import rpc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [31:0] ID_WORD  = 32'h7A31_19E5,
  parameter logic [7:0]  REV_ID   = 8'h01,
  parameter bit          HAS_PCIE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              set_valid,
  input  logic [ADDR_W-3:0] set_idx,
  input  logic [31:0]       set_bits,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              ntf_valid,
  output logic [ADDR_W-3:0] ntf_index,
  output logic [31:0]       ntf_old,
  output logic [31:0]       ntf_new,
  output logic [31:0]       ntf_mask
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned SLOTS  = 1 << IDX_W;
  localparam int unsigned NUM_DW = HAS_PCIE ? (HDR_DW + CAP_DW) : HDR_DW;

  logic [IDX_W-1:0] idx;
  logic             in_rng, acc, wr_fire, size_ok;
  bit_attr_t        attr_c;
  word_t            old_v, lane_m, merged, rd_val;
  word_t            dw_rd [SLOTS];

  assign idx    = req_addr[ADDR_W-1:2];
  assign in_rng = (32'(idx) < NUM_DW);

  always_comb begin
    attr_c = dw_attr(32'(idx));
    old_v  = in_rng ? (dw_rd[idx] & ~attr_c.rsvd) : '0;
  end

  rpc_lane u_lane (
    .ofs     (req_addr[1:0]),
    .size    (req_size),
    .wdata   (req_wdata),
    .old     (old_v),
    .rw_m    (attr_c.rw),
    .w1c_m   (attr_c.w1c),
    .size_ok (size_ok),
    .lane_m  (lane_m),
    .merged  (merged),
    .rd_val  (rd_val)
  );

  assign acc     = req_valid & req_ready;
  assign wr_fire = acc & req_write & size_ok & in_rng;

  for (genvar g = 0; g < SLOTS; g++) begin : g_dw
    if (g < NUM_DW) begin : g_on
      rpc_dword #(
        .IDX(g), .ID_WORD(ID_WORD), .REV_ID(REV_ID), .HAS_PCIE(HAS_PCIE)
      ) u_dw (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_fire && (idx == IDX_W'(g))),
        .wr_val   (merged),
        .set_en   (set_valid && (set_idx == IDX_W'(g))),
        .set_bits (set_bits),
        .rd       (dw_rd[g])
      );
    end else begin : g_off
      assign dw_rd[g] = '0;
    end
  end

  // response and notification: next-state
  logic       ready_q, rsp_valid_q, rsp_err_q, ntf_valid_q;
  logic       rsp_valid_n, rsp_err_n;
  word_t      rsp_rdata_q, rsp_rdata_n;
  logic [IDX_W-1:0] ntf_index_q;
  word_t      ntf_old_q, ntf_new_q, ntf_mask_q;

  always_comb begin
    rsp_valid_n = acc;
    rsp_err_n   = acc & ~size_ok;
    rsp_rdata_n = (~req_write & size_ok) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      ntf_valid_q <= 1'b0;
      ntf_index_q <= '0;
      ntf_old_q   <= '0;
      ntf_new_q   <= '0;
      ntf_mask_q  <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= rsp_valid_n;
      ntf_valid_q <= wr_fire;
      if (acc) begin
        rsp_err_q   <= rsp_err_n;
        rsp_rdata_q <= rsp_rdata_n;
      end
      if (wr_fire) begin
        ntf_index_q <= idx;
        ntf_old_q   <= old_v;
        ntf_new_q   <= merged;
        ntf_mask_q  <= lane_m;
      end
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;
  assign ntf_valid = ntf_valid_q;
  assign ntf_index = ntf_index_q;
  assign ntf_old   = ntf_old_q;
  assign ntf_new   = ntf_new_q;
  assign ntf_mask  = ntf_mask_q;

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  assert_rsp_only_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(acc));
  assert_outside_lanes_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (((ntf_new ^ ntf_old) & ~ntf_mask) == '0));
  assert_ro_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (((ntf_new ^ ntf_old) & ~(dw_attr(32'(ntf_index)).rw | dw_attr(32'(ntf_index)).w1c)) == '0));
  assert_w1c_never_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ((ntf_new & ~ntf_old & dw_attr(32'(ntf_index)).w1c) == '0));
  assert_old_rsvd_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> ((ntf_old & dw_attr(32'(ntf_index)).rsvd) == '0));
  assert_ntf_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> (32'(ntf_index) < NUM_DW));
endmodule

// File: tb/rp_cfg_space_test.sv
`timescale 1ns/1ps
module rp_cfg_space_test;
  localparam logic [31:0] TB_ID  = 32'h5A17_C0DE;
  localparam logic [7:0]  TB_REV = 8'h03;

  logic        clk, rst_n;
  logic        req_valid, req_write, req_ready, req_ready_np;
  logic [7:0]  req_addr;
  logic [2:0]  req_size;
  logic [31:0] req_wdata;
  logic        set_valid;
  logic [5:0]  set_idx;
  logic [31:0] set_bits;
  logic        rsp_valid, rsp_err, ntf_valid;
  logic [31:0] rsp_rdata, ntf_old, ntf_new, ntf_mask;
  logic [5:0]  ntf_index;
  logic        np_rsp_valid, np_rsp_err, np_ntf_valid;
  logic [31:0] np_rsp_rdata, np_ntf_old, np_ntf_new, np_ntf_mask;
  logic [5:0]  np_ntf_index;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [64];

  rp_cfg_space #(.ADDR_W(8), .ID_WORD(TB_ID), .REV_ID(TB_REV), .HAS_PCIE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .set_valid(set_valid), .set_idx(set_idx), .set_bits(set_bits),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ntf_valid(ntf_valid), .ntf_index(ntf_index), .ntf_old(ntf_old),
    .ntf_new(ntf_new), .ntf_mask(ntf_mask));

  rp_cfg_space #(.ADDR_W(8), .ID_WORD(TB_ID), .REV_ID(TB_REV), .HAS_PCIE(1'b0)) uut_np (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready_np),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .set_valid(set_valid), .set_idx(set_idx), .set_bits(set_bits),
    .rsp_valid(np_rsp_valid), .rsp_err(np_rsp_err), .rsp_rdata(np_rsp_rdata),
    .ntf_valid(np_ntf_valid), .ntf_index(np_ntf_index), .ntf_old(np_ntf_old),
    .ntf_new(np_ntf_new), .ntf_mask(np_ntf_mask));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // attribute masks taken from the requirement list
  function automatic logic [95:0] tb_attr(input int i);   // {rw, w1c, rsvd}
    case (i)
      1:          return {32'h0000_0147, 32'hF900_0000, 32'h004F_FC00};
      6:          return {32'h00FF_FFFF, 32'h0, 32'h0};
      7:          return {32'h0000_F0F0, 32'hF900_0000, 32'h005F_0000};
      8, 9:       return {32'hFFF0_FFF0, 32'h0, 32'h0};
      10, 11, 12: return {32'hFFFF_FFFF, 32'h0, 32'h0};
      13:         return {32'h0, 32'h0, 32'hFFFF_FF00};
      14:         return {32'hFFFF_F801, 32'h0, 32'h0000_07FE};
      15:         return {32'h0B6F_00FF, 32'h0400_0000, 32'hF010_0000};
      18:         return {32'h0000_FFFF, 32'h000F_0000, 32'hFFE0_0000};
      19:         return {32'h0, 32'h0, 32'h0080_0000};
      20:         return {32'h0000_0FFB, 32'hC000_0000, 32'h0000_F004};
      22:         return {32'h0000_1FFF, 32'h011F_0000, 32'hFE00_F000};
      23:         return {32'h0000_001F, 32'h0, 32'hFFFE_FFE0};
      24:         return {32'h0, 32'h0001_0000, 32'hFFFC_0000};
      default:    return 96'h0;
    endcase
  endfunction

  function automatic logic [31:0] full_val(input int i);
    logic [95:0] a;
    a = tb_attr(i);
    return (i < 31) ? (mdl[i] & ~a[31:0]) : 32'h0;
  endfunction

  task automatic do_req(input logic w, input logic [7:0] a, input logic [2:0] s,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [2:0] s);
    logic [31:0] f, e;
    logic [4:0]  sh;
    f  = full_val(int'(a[7:2]));
    sh = {a[1:0], 3'b000};
    case (s)
      3'd1:    e = (f >> sh) & 32'hFF;
      3'd2:    e = (f >> sh) & 32'hFFFF;
      3'd4:    e = f;
      default: e = 32'h0;
    endcase
    do_req(1'b0, a, s, 32'h0);
    chk({req, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
    chk({req, " rsp_err"}, {31'h0, rsp_err}, {31'h0, !(s == 1 || s == 2 || s == 4)});
    chk({req, " rdata"}, rsp_rdata, e);
  endtask

  task automatic wr_chk(input logic [7:0] a, input logic [2:0] s, input logic [31:0] d,
                        input logic [31:0] hw_set);
    int          i;
    logic [95:0] at;
    logic [31:0] old, lane, wsh, nv;
    logic [4:0]  sh;
    logic        ok;
    i    = int'(a[7:2]);
    at   = tb_attr(i);
    sh   = {a[1:0], 3'b000};
    ok   = (s == 1 || s == 2 || s == 4);
    lane = (s == 1) ? (32'hFF << sh) : (s == 2) ? (32'hFFFF << sh) : 32'hFFFF_FFFF;
    wsh  = d << sh;
    old  = full_val(i);
    nv   = (old & ~(at[95:64] & lane)) | (wsh & at[95:64] & lane);
    nv   = nv & ~(wsh & at[63:32] & lane);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    set_valid = (hw_set != 0); set_idx = a[7:2]; set_bits = hw_set;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; set_valid = 1'b0;
    chk("R10 write rsp_valid", {31'h0, rsp_valid}, 32'h1);
    chk("R4 write rsp_err", {31'h0, rsp_err}, {31'h0, !ok});
    if (ok && i < 31) begin
      chk("R9 ntf_valid", {31'h0, ntf_valid}, 32'h1);
      chk("R9 ntf_index", {26'h0, ntf_index}, 32'(i));
      chk("R9 ntf_old", ntf_old, old);
      chk("R5 ntf_new", ntf_new, nv);
      chk("R5 ntf_mask", ntf_mask, lane);
      mdl[i] = nv;
    end else begin
      chk("R8 no ntf", {31'h0, ntf_valid}, 32'h0);
    end
    if (i < 31) mdl[i] = mdl[i] | (hw_set & at[63:32]);
  endtask

  task automatic set_pulse(input int i, input logic [31:0] b);
    logic [95:0] at;
    at = tb_attr(i);
    @(negedge clk);
    set_valid = 1'b1; set_idx = 6'(i); set_bits = b;
    @(negedge clk);
    set_valid = 1'b0;
    if (i < 31) mdl[i] = mdl[i] | (b & at[63:32]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0;
    req_wdata = '0; set_valid = 1'b0; set_idx = '0; set_bits = '0;
    for (int i = 0; i < 64; i++) mdl[i] = 32'h0;
    mdl[0] = TB_ID; mdl[1] = 32'h0010_0000; mdl[2] = {24'h0604_00, TB_REV};
    mdl[3] = 32'h0001_0010; mdl[13] = 32'h40; mdl[16] = 32'h0142_0010;
    repeat (3) @(negedge clk);
    chk("R10 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R9 reset ntf_valid", {31'h0, ntf_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", {31'h0, req_ready}, 32'h1);

    // R1: reset image
    rd_chk("R1 id", 8'h00, 3'd4);
    rd_chk("R1 status", 8'h04, 3'd4);
    chk("R1 no-cap status", np_rsp_rdata, 32'h0010_0000);
    rd_chk("R1 class", 8'h08, 3'd4);
    rd_chk("R1 hdr type", 8'h0C, 3'd4);
    rd_chk("R1 cap ptr", 8'h34, 3'd4);
    chk("R1 no-cap ptr", np_rsp_rdata, 32'h0);
    rd_chk("R1 cap hdr", 8'h40, 3'd4);
    chk("R8 no-cap window", np_rsp_rdata, 32'h0);
    chk("R1 class value", mdl[2], 32'h0604_0003);
    rd_chk("R8 past end", 8'h7C, 3'd4);
    rd_chk("R8 top", 8'hFC, 3'd4);

    // R3: sub-dword reads of identity fields
    for (int o = 0; o < 4; o++) begin
      rd_chk("R3 byte", 8'(o), 3'd1);
      rd_chk("R3 half", 8'(8 + o), 3'd2);
    end

    // R4: illegal sizes
    for (int s = 0; s < 8; s++) begin
      if (s != 1 && s != 2 && s != 4) begin
        wr_chk(8'h18, 3'(s), 32'hFFFF_FFFF, 32'h0);
        rd_chk("R4 unchanged", 8'h18, 3'd4);
        rd_chk("R4 read err", 8'h18, 3'(s));
      end
    end

    // main sweep: R5 R6 R11 R12 R2 R8
    for (int i = 0; i < 32; i++) begin
      for (int o = 0; o < 4; o++) begin
        for (int k = 0; k < 3; k++) begin
          for (int p = 0; p < 2; p++) begin
            logic [2:0]  s;
            logic [31:0] d;
            s = (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : 3'd4;
            d = (p == 0) ? 32'hA53C_F069 : 32'h5AC3_0F96;
            d = d ^ (32'(i) * 32'h0103_0507) ^ (32'(o) << 12);
            set_pulse(i, 32'hFFFF_FFFF);
            rd_chk("R6 set visible", 8'(i * 4), 3'd4);
            wr_chk(8'(i * 4 + o), s, d, 32'h0);
            rd_chk("R11 R12 readback", 8'(i * 4), 3'd4);
            rd_chk("R3 sub readback", 8'(i * 4 + o), s);
          end
        end
      end
    end

    // R6: set beats clear in the same cycle
    set_pulse(1, 32'hFFFF_FFFF);
    wr_chk(8'h04, 3'd4, 32'hFFFF_FFFF, 32'h0100_0000);
    rd_chk("R6 set wins", 8'h04, 3'd4);
    chk("R6 set wins bit", mdl[1] & 32'hF900_0000, 32'h0100_0000);

    // R7: identity dwords survive everything
    rd_chk("R7 id", 8'h00, 3'd4);
    chk("R7 id value", rsp_rdata, TB_ID);
    rd_chk("R7 class", 8'h08, 3'd4);
    chk("R7 class value", rsp_rdata, {24'h0604_00, TB_REV});
    rd_chk("R7 hdr", 8'h0C, 3'd4);
    chk("R7 hdr value", rsp_rdata, 32'h0001_0010);
    rd_chk("R7 cap ptr", 8'h34, 3'd4);
    chk("R7 cap ptr value", rsp_rdata, 32'h40);
    rd_chk("R7 cap hdr", 8'h40, 3'd4);
    chk("R7 cap hdr value", rsp_rdata, 32'h0142_0010);

    finish_run();
  end
endmodule